// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block switches individual on-chip power domains off and back on. A request names one domain by index and says which way to go. The sequencer then walks that domain's control bits through a strictly ordered handshake, waiting a settle interval between steps.

Going down, the sequence is: gate the clock, isolate the outputs, assert reset, open the power switch. It then waits for the switch to acknowledge. Going up, the sequence runs in the reverse order and starts by closing the switch. Reset, isolation and clock are only touched once the acknowledge has dropped.

The acknowledge from the switch is synchronized before use, and each wait on it is bounded by a poll limit that depends on the direction. When a sequence ends, the block gives a one-cycle done pulse. A sticky error flag reports a timeout or a bad index. A combinational read port exposes the four control vectors and the synchronized acknowledge.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset every domain is on: all clock-enable and reset-release bits are 1, all isolation and power-down bits are 0, and busy, done and err are 0.
- R2: An off request for domain d clears clock-enable bit d at the accepting edge. It sets isolation bit d SETTLE cycles later, clears reset-release bit d (asserting reset) 2*SETTLE cycles after acceptance, and sets power-down bit d 3*SETTLE cycles after acceptance. SETTLE is derived from CLK_MHZ and SETTLE_NS, rounded up, with a minimum of 1.
- R3: After an off request sets its power-down bit, the sequence ends as soon as the synchronized acknowledge bit d reads 1. Done is then high for exactly one cycle, busy is low while done is high, and err stays 0.
- R4: An on request clears power-down bit d at the accepting edge. After the synchronized acknowledge bit d reads 0, it sets reset-release bit d. SETTLE cycles later it clears isolation bit d, and SETTLE cycles after that it sets clock-enable bit d. Done follows SETTLE cycles after the clock step.
- R5: If the acknowledge never reads 1 during an off sequence, done and err rise exactly OFF_POLLS cycles after the power-down bit was set. The domain is left gated, isolated, in reset and powered down.
- R6: If the acknowledge never reads 0 during an on sequence, done and err rise exactly ON_POLLS cycles after acceptance. Clock-enable, isolation and reset-release bit d keep their off values (0, 1, 0), and power-down bit d is 0.
- R7: Busy is high from the accepting edge until the edge that raises done. A request made while busy is ignored, and no other domain's bits change.
- R8: A request whose index is NUM_DOM or above raises done and err at the accepting edge. It changes no control bit and busy stays low.
- R9: The error flag holds until the next request with a valid index is accepted, and that acceptance clears it.
- R10: The read port is combinational on a byte offset. Offset 0x18 returns clock enable, 0x1C reset release, 0x20 isolation, 0x24 power-down and 0x28 the synchronized acknowledge. Bit d belongs to domain d, unused upper bits read 0, and any other offset reads 0.
- R11: The acknowledge input reaches the synchronized vector through two flops, so a change is visible two edges later and not after one.
- R12: At all times, a domain's clock is enabled only if it is out of reset, not isolated and powered. A powered-down domain is isolated and in reset. No more than one domain's control bits change in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_dom | input | IDX_W | Domain index of the request |
| req_on | input | 1 | 1 = power on, 0 = power off |
| ack_async | input | NUM_DOM | Power switch acknowledge, asynchronous, 1 = switch open |
| clk_en_o | output | NUM_DOM | Per-domain clock enable |
| rst_rel_o | output | NUM_DOM | Per-domain reset release (0 holds reset) |
| iso_en_o | output | NUM_DOM | Per-domain output isolation |
| pwr_dn_o | output | NUM_DOM | Per-domain power-switch open request |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Sticky timeout or bad-index flag |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Read data |

## Verification
Some properties are checked on every cycle. These are the ordering invariants between a domain's clock, reset, isolation and power bits, the rule that only one domain moves per cycle, and the freezing of all vectors while idle with no request. The done and busy relation, the immediate error for a bad index, the clearing of the error on a valid request, and the bounds of the internal counters are also checked every cycle.

Other behaviour only the bench scenarios can show. These cover the exact settle spacing between steps, the acknowledge-dependent finish time, and the exact cycle at which each timeout fires. They also cover what state a failed power-on leaves behind, the two-edge synchronizer latency, and the read-port offsets.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OFF_ISO,
    ST_OFF_RST,
    ST_OFF_PD,
    ST_OFF_POLL,
    ST_ON_POLL,
    ST_ON_ISO,
    ST_ON_CLK,
    ST_ON_FIN
  } seq_st_e;

  // Domain bit assignment
  localparam int unsigned DOM_SIMD0  = 0;
  localparam int unsigned DOM_SIMD1  = 1;
  localparam int unsigned DOM_GFX    = 2;
  localparam int unsigned DOM_VDEC   = 3;
  localparam int unsigned DOM_VOUT   = 4;
  localparam int unsigned DOM_RAST2D = 5;
  localparam int unsigned DOM_TOP    = 6;

  // Read offsets
  localparam logic [7:0] OFS_CLK = 8'h18;
  localparam logic [7:0] OFS_RST = 8'h1C;
  localparam logic [7:0] OFS_ISO = 8'h20;
  localparam logic [7:0] OFS_PD  = 8'h24;
  localparam logic [7:0] OFS_ACK = 8'h28;

  // Settle interval in clock cycles, rounded up, at least one
  function automatic int unsigned settle_cycles(input int unsigned mhz,
                                                input int unsigned ns);
    int unsigned c;
    c = (mhz * ns + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic idx_valid(input int unsigned idx, input int unsigned n);
    return idx < n;
  endfunction

  // One-hot select of a domain; zero when out of range
  function automatic logic [31:0] dom_onehot(input int unsigned idx,
                                             input int unsigned n);
    return (idx < n) ? (32'd1 << idx) : 32'd0;
  endfunction

endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_async;
      hold_q <= meta_q;
    end
  end

  assign q_sync = hold_q;
endmodule

// File: rtl/pds_count.sv
module pds_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (en && !at_last) cnt_q <= cnt_q + W'(1);
  end

  assign cnt     = cnt_q;
  assign at_last = (cnt_q == last);
endmodule

// File: rtl/pds_rdport.sv
module pds_rdport #(
  parameter int NUM_DOM = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [NUM_DOM-1:0] clk_en,
  input  logic [NUM_DOM-1:0] rst_rel,
  input  logic [NUM_DOM-1:0] iso_en,
  input  logic [NUM_DOM-1:0] pwr_dn,
  input  logic [NUM_DOM-1:0] ack_sync,
  output logic [DATA_W-1:0]  rd_data
);
  import pds_pkg::*;

  localparam int NSRC = 5;

  logic [NUM_DOM-1:0] src [NSRC];
  logic [7:0]         ofs [NSRC];
  logic [NSRC-1:0]    hit;

  assign src[0] = clk_en;   assign ofs[0] = OFS_CLK;
  assign src[1] = rst_rel;  assign ofs[1] = OFS_RST;
  assign src[2] = iso_en;   assign ofs[2] = OFS_ISO;
  assign src[3] = pwr_dn;   assign ofs[3] = OFS_PD;
  assign src[4] = ack_sync; assign ofs[4] = OFS_ACK;

  for (genvar k = 0; k < NSRC; k++) begin : g_dec
    assign hit[k] = (rd_addr == ADDR_W'(ofs[k]));
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (hit[k]) rd_data = DATA_W'(src[k]);
    end
  end
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
  parameter int NUM_DOM   = 7,
  parameter int CLK_MHZ   = 250,
  parameter int SETTLE_NS = 5000,
  parameter int OFF_POLLS = 1000,
  parameter int ON_POLLS  = 10000,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = $clog2(NUM_DOM + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_dom,
  input  logic               req_on,
  input  logic [NUM_DOM-1:0] ack_async,
  output logic [NUM_DOM-1:0] clk_en_o,
  output logic [NUM_DOM-1:0] rst_rel_o,
  output logic [NUM_DOM-1:0] iso_en_o,
  output logic [NUM_DOM-1:0] pwr_dn_o,
  output logic               busy,
  output logic               done,
  output logic               err,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data
);
  import pds_pkg::*;

  localparam int SETTLE_CYC = int'(settle_cycles(CLK_MHZ, SETTLE_NS));
  localparam int POLL_MAX   = int'(max_u(OFF_POLLS, ON_POLLS));
  localparam int SET_W      = $clog2(SETTLE_CYC + 1);
  localparam int POLL_W     = $clog2(POLL_MAX + 1);

  seq_st_e            st_q;
  logic [IDX_W-1:0]   dom_q;
  logic [NUM_DOM-1:0] clk_q, rst_q, iso_q, pd_q;
  logic               done_q, err_q;

  // Named internal events
  logic               accept_w;
  logic               idx_ok_w;
  logic [NUM_DOM-1:0] req_mask_w;
  logic [NUM_DOM-1:0] cur_mask_w;
  logic [NUM_DOM-1:0] ack_sync_w;
  logic               ack_bit_w;
  logic               in_settle_w;
  logic               settle_fire_w;
  logic               in_poll_w;
  logic               poll_last_w;
  logic               poll_ok_w;
  logic               poll_to_w;
  logic               step_wr_w;
  logic               pd_wr_w;
  logic [SET_W-1:0]   settle_cnt_w;
  logic [POLL_W-1:0]  poll_cnt_w;
  logic [POLL_W-1:0]  poll_lim_w;

  pds_sync #(.W(NUM_DOM)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ack_async), .q_sync(ack_sync_w)
  );

  assign busy       = (st_q != ST_IDLE);
  assign accept_w   = req_valid && !busy;
  assign idx_ok_w   = idx_valid(int'(req_dom), NUM_DOM);
  assign req_mask_w = NUM_DOM'(dom_onehot(int'(req_dom), NUM_DOM));
  assign cur_mask_w = NUM_DOM'(dom_onehot(int'(dom_q), NUM_DOM));
  assign ack_bit_w  = |(ack_sync_w & cur_mask_w);

  assign in_settle_w = (st_q == ST_OFF_ISO) || (st_q == ST_OFF_RST) ||
                       (st_q == ST_OFF_PD)  || (st_q == ST_ON_ISO)  ||
                       (st_q == ST_ON_CLK)  || (st_q == ST_ON_FIN);
  assign in_poll_w   = (st_q == ST_OFF_POLL) || (st_q == ST_ON_POLL);

  // Settle timer: restarts on every step write
  pds_count #(.W(SET_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr(step_wr_w), .en(in_settle_w),
    .last(SET_W'(SETTLE_CYC - 1)), .cnt(settle_cnt_w), .at_last(settle_fire_w_raw)
  );
  logic settle_fire_w_raw;
  assign settle_fire_w = in_settle_w && settle_fire_w_raw;

  // Poll counter: one poll per cycle, limit depends on direction
  assign poll_lim_w = (st_q == ST_ON_POLL) ? POLL_W'(ON_POLLS - 1)
                                           : POLL_W'(OFF_POLLS - 1);
  pds_count #(.W(POLL_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(pd_wr_w), .en(in_poll_w),
    .last(poll_lim_w), .cnt(poll_cnt_w), .at_last(poll_last_w)
  );

  assign poll_ok_w = ((st_q == ST_OFF_POLL) &&  ack_bit_w) ||
                     ((st_q == ST_ON_POLL)  && !ack_bit_w);
  assign poll_to_w = in_poll_w && !poll_ok_w && poll_last_w;

  // Edges at which a control step is written (restarts settle timer)
  assign pd_wr_w   = (accept_w && idx_ok_w && req_on) ||
                     ((st_q == ST_OFF_PD) && settle_fire_w);
  assign step_wr_w = (accept_w && idx_ok_w && !req_on) ||
                     ((st_q == ST_ON_POLL) && poll_ok_w) ||
                     (settle_fire_w && (st_q != ST_OFF_PD) && (st_q != ST_ON_FIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dom_q  <= '0;
      clk_q  <= '1;
      rst_q  <= '1;
      iso_q  <= '0;
      pd_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept_w) begin
            if (!idx_ok_w) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              err_q <= 1'b0;
              dom_q <= req_dom;
              if (req_on) begin
                pd_q <= pd_q & ~req_mask_w;
                st_q <= ST_ON_POLL;
              end else begin
                clk_q <= clk_q & ~req_mask_w;
                st_q  <= ST_OFF_ISO;
              end
            end
          end
        end
        ST_OFF_ISO: if (settle_fire_w) begin
          iso_q <= iso_q | cur_mask_w;
          st_q  <= ST_OFF_RST;
        end
        ST_OFF_RST: if (settle_fire_w) begin
          rst_q <= rst_q & ~cur_mask_w;
          st_q  <= ST_OFF_PD;
        end
        ST_OFF_PD: if (settle_fire_w) begin
          pd_q <= pd_q | cur_mask_w;
          st_q <= ST_OFF_POLL;
        end
        ST_OFF_POLL: begin
          if (poll_ok_w || poll_to_w) begin
            done_q <= 1'b1;
            err_q  <= poll_to_w;
            st_q   <= ST_IDLE;
          end
        end
        ST_ON_POLL: begin
          if (poll_ok_w) begin
            rst_q <= rst_q | cur_mask_w;
            st_q  <= ST_ON_ISO;
          end else if (poll_to_w) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_ON_ISO: if (settle_fire_w) begin
          iso_q <= iso_q & ~cur_mask_w;
          st_q  <= ST_ON_CLK;
        end
        ST_ON_CLK: if (settle_fire_w) begin
          clk_q <= clk_q | cur_mask_w;
          st_q  <= ST_ON_FIN;
        end
        ST_ON_FIN: if (settle_fire_w) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign clk_en_o  = clk_q;
  assign rst_rel_o = rst_q;
  assign iso_en_o  = iso_q;
  assign pwr_dn_o  = pd_q;
  assign done      = done_q;
  assign err       = err_q;

  pds_rdport #(.NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .rd_addr(rd_addr), .clk_en(clk_q), .rst_rel(rst_q), .iso_en(iso_q),
    .pwr_dn(pd_q), .ack_sync(ack_sync_w), .rd_data(rd_data)
  );
endmodule

// File: rtl/pds_sva.sv
module pds_sva #(
  parameter int NUM_DOM    = 7,
  parameter int SET_W      = 4,
  parameter int POLL_W     = 4,
  parameter int SETTLE_CYC = 4,
  parameter int POLL_MAX   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic               accept_w,
  input logic               idx_ok_w,
  input logic [NUM_DOM-1:0] clk_en_o,
  input logic [NUM_DOM-1:0] rst_rel_o,
  input logic [NUM_DOM-1:0] iso_en_o,
  input logic [NUM_DOM-1:0] pwr_dn_o,
  input logic [SET_W-1:0]   settle_cnt_w,
  input logic [POLL_W-1:0]  poll_cnt_w
);
  assert_clk_needs_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o & (iso_en_o | ~rst_rel_o | pwr_dn_o)) == '0);

  assert_pd_isolated_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn_o & (~iso_en_o | rst_rel_o)) == '0);

  assert_one_domain_moves_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones((clk_en_o ^ $past(clk_en_o)) | (rst_rel_o ^ $past(rst_rel_o)) |
               (iso_en_o ^ $past(iso_en_o)) | (pwr_dn_o ^ $past(pwr_dn_o))) <= 1);

  assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept_w) |=> ($stable(clk_en_o) && $stable(rst_rel_o) &&
                              $stable(iso_en_o) && $stable(pwr_dn_o)));

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_bad_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !idx_ok_w) |=> (done && err && !busy));

  assert_err_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && idx_ok_w) |=> !err);

  assert_settle_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(settle_cnt_w) < SETTLE_CYC);

  assert_poll_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(poll_cnt_w) < POLL_MAX);
endmodule

bind pwr_dom_seq pds_sva #(
  .NUM_DOM(NUM_DOM), .SET_W(SET_W), .POLL_W(POLL_W),
  .SETTLE_CYC(SETTLE_CYC), .POLL_MAX(POLL_MAX)
) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .accept_w(accept_w), .idx_ok_w(idx_ok_w),
  .clk_en_o(clk_en_o), .rst_rel_o(rst_rel_o), .iso_en_o(iso_en_o),
  .pwr_dn_o(pwr_dn_o), .settle_cnt_w(settle_cnt_w), .poll_cnt_w(poll_cnt_w)
);

// File: tb/pwr_dom_seq_test.sv
module pwr_dom_seq_test;
  localparam int ND   = 7;
  localparam int IW   = 3;
  localparam int S    = 4;    // CLK_MHZ=1, SETTLE_NS=4000
  localparam int OFFP = 20;
  localparam int ONP  = 30;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [IW-1:0] req_dom = '0;
  logic req_on = 0;
  logic [ND-1:0] ack_async;
  logic [ND-1:0] clk_en_o, rst_rel_o, iso_en_o, pwr_dn_o;
  logic busy, done, err;
  logic [7:0] rd_addr = 8'h00;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  pwr_dom_seq #(.NUM_DOM(ND), .CLK_MHZ(1), .SETTLE_NS(4000),
                .OFF_POLLS(OFFP), .ON_POLLS(ONP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dom(req_dom),
    .req_on(req_on), .ack_async(ack_async), .clk_en_o(clk_en_o),
    .rst_rel_o(rst_rel_o), .iso_en_o(iso_en_o), .pwr_dn_o(pwr_dn_o),
    .busy(busy), .done(done), .err(err), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Power switch model: acknowledge follows power-down after a delay
  logic [ND-1:0] hist [16];
  int dly = 0;
  logic [ND-1:0] ovr_mask = '0, ovr_val = '0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) hist[k] <= '0;
    end else begin
      hist[0] <= pwr_dn_o;
      for (int k = 1; k < 16; k++) hist[k] <= hist[k-1];
    end
  end
  assign ack_async = (hist[dly] & ~ovr_mask) | (ovr_val & ovr_mask);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Change monitor for the domain under test
  int mon_dom = 0;
  int t_clk, t_iso, t_rst, t_pd;
  logic [ND-1:0] p_clk = '1, p_rst = '1, p_iso = '0, p_pd = '0;
  always @(negedge clk) begin
    if (clk_en_o[mon_dom]  != p_clk[mon_dom]) t_clk = cyc;
    if (iso_en_o[mon_dom]  != p_iso[mon_dom]) t_iso = cyc;
    if (rst_rel_o[mon_dom] != p_rst[mon_dom]) t_rst = cyc;
    if (pwr_dn_o[mon_dom]  != p_pd[mon_dom])  t_pd  = cyc;
    p_clk = clk_en_o; p_iso = iso_en_o; p_rst = rst_rel_o; p_pd = pwr_dn_o;
  end

  int nchk = 0, nerr = 0;
  logic [ND-1:0] e_clk = '1, e_rst = '1, e_iso = '0, e_pd = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req);
    check(clk_en_o == e_clk, req, clk_en_o, e_clk);
    check(rst_rel_o == e_rst, req, rst_rel_o, e_rst);
    check(iso_en_o == e_iso, req, iso_en_o, e_iso);
    check(pwr_dn_o == e_pd, req, pwr_dn_o, e_pd);
  endtask

  int acc, dc;
  bit busy_acc, err_acc;

  // Issue a request, optionally poke a second request while busy
  task automatic run(input int d, input bit on, input bit poke, input int pdom);
    @(negedge clk);
    mon_dom = (d < ND) ? d : 0;
    t_clk = -1; t_iso = -1; t_rst = -1; t_pd = -1;
    req_valid = 1; req_dom = IW'(d); req_on = on;
    @(negedge clk);
    req_valid = 0;
    acc = cyc; busy_acc = busy; err_acc = err;
    dc = -1;
    if (done) dc = cyc;
    if (poke && dc < 0) begin
      req_valid = 1; req_dom = IW'(pdom); req_on = 0;
      @(negedge clk);
      req_valid = 0;
    end
    for (int i = 0; i < 500 && dc < 0; i++) begin
      @(negedge clk);
      if (done) dc = cyc;
    end
    check(busy == 0, "R7 busy low at done", busy, 0);
    @(negedge clk);
    check(done == 0, "R3 done one cycle", done, 0);
  endtask

  task automatic do_off(input int d, input bit timeout, input bit poke);
    run(d, 0, poke, (d + 2) % ND);
    check(busy_acc == 1, "R7 busy after accept", busy_acc, 1);
    check(err_acc == 0, "R9 err cleared on accept", err_acc, 0);
    check(t_clk == acc, "R2 clock gate step", t_clk, acc);
    check(t_iso == acc + S, "R2 isolate step", t_iso, acc + S);
    check(t_rst == acc + 2*S, "R2 reset step", t_rst, acc + 2*S);
    check(t_pd == acc + 3*S, "R2 power-down step", t_pd, acc + 3*S);
    e_clk[d] = 0; e_iso[d] = 1; e_rst[d] = 0; e_pd[d] = 1;
    if (timeout) begin
      check(dc == t_pd + OFFP, "R5 off timeout cycle", dc, t_pd + OFFP);
      check(err == 1, "R5 off timeout err", err, 1);
    end else begin
      check(dc > t_pd && dc <= t_pd + dly + 4, "R3 off finish on ack", dc, t_pd + dly + 4);
      check(err == 0, "R3 no error", err, 0);
    end
    check_vec(poke ? "R7 poke ignored" : "R2 final off state");
  endtask

  task automatic do_on(input int d, input bit timeout);
    bit had_pd;
    had_pd = e_pd[d];
    run(d, 1, 0, 0);
    check(busy_acc == 1, "R7 busy after accept", busy_acc, 1);
    check(err_acc == 0, "R9 err cleared on accept", err_acc, 0);
    if (had_pd) check(t_pd == acc, "R4 power-down cleared first", t_pd, acc);
    e_pd[d] = 0;
    if (timeout) begin
      check(dc == acc + ONP, "R6 on timeout cycle", dc, acc + ONP);
      check(err == 1, "R6 on timeout err", err, 1);
      check(t_rst == -1 && t_iso == -1 && t_clk == -1, "R6 no later step", t_rst, -1);
    end else begin
      check(t_rst > acc && t_rst <= acc + dly + 4, "R4 reset release after ack", t_rst, acc + dly + 4);
      check(t_iso == t_rst + S, "R4 isolation release", t_iso, t_rst + S);
      check(t_clk == t_iso + S, "R4 clock enable", t_clk, t_iso + S);
      check(dc == t_clk + S, "R4 done after settle", dc, t_clk + S);
      check(err == 0, "R4 no error", err, 0);
      e_clk[d] = 1; e_iso[d] = 0; e_rst[d] = 1;
    end
    check_vec(timeout ? "R6 held off state" : "R4 final on state");
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_vec("R1 reset vectors");
    check(busy == 0 && done == 0 && err == 0, "R1 reset status", {busy, done, err}, 0);

    // R11 synchronizer latency
    @(negedge clk);
    ovr_mask = '1; ovr_val = 7'h55; rd_addr = 8'h28;
    @(negedge clk); #1;
    check(rd_data == 0, "R11 not visible after one edge", rd_data, 0);
    @(negedge clk); #1;
    check(rd_data == 32'h55, "R11 visible after two edges", rd_data, 32'h55);
    ovr_mask = '0; ovr_val = '0;
    repeat (4) @(negedge clk);

    // Directed sequences
    dly = 3;
    do_off(2, 0, 0);
    do_on(2, 0);
    do_off(4, 0, 1);          // R7 second request while busy
    // R8 bad index
    run(7, 0, 0, 0);
    check(dc == acc && err == 1, "R8 immediate error", dc, acc);
    check(busy_acc == 0, "R8 no busy", busy_acc, 0);
    check_vec("R8 vectors untouched");
    // R9 valid request clears err
    do_on(4, 0);
    // R5 off timeout
    ovr_mask[5] = 1; ovr_val[5] = 0;
    do_off(5, 1, 0);
    ovr_mask = '0;
    repeat (12) @(negedge clk);
    // R6 on timeout, then recovery
    ovr_mask[5] = 1; ovr_val[5] = 1;
    do_on(5, 1);
    ovr_mask = '0;
    do_on(5, 0);
    // Corner: zero extra ack delay, edge domains
    dly = 0;
    do_off(0, 0, 0);
    do_off(6, 0, 0);
    repeat (6) @(negedge clk);
    // R10 reads
    rd_chk(8'h18, 32'(e_clk), "R10 clock enable read");
    rd_chk(8'h1C, 32'(e_rst), "R10 reset read");
    rd_chk(8'h20, 32'(e_iso), "R10 isolation read");
    rd_chk(8'h24, 32'(e_pd),  "R10 power-down read");
    rd_chk(8'h28, 32'(e_pd),  "R10 ack read");
    rd_chk(8'h2C, 32'h0,      "R10 unmapped read");
    do_on(0, 0);
    do_on(6, 0);

    // Random toggling of domains
    for (int it = 0; it < 40; it++) begin
      int d;
      d = int'($urandom % ND);
      dly = int'($urandom % 8);
      if (e_clk[d]) do_off(d, 0, 0);
      else          do_on(d, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule